// File: doc/BRIEF.md
# Duty-Cycle Command Clock Transmitter

The block generates a continuous reference clock for a remote acquisition module. It sends command bytes over that same wire, so no separate data line is needed. The clock always keeps the same period. In idle it runs at half duty. To signal data, the block narrows the high time to a quarter of the period for a short run of periods, called a marking burst. The receiver sees each burst as a drop in the DC level of the clock.

Commands enter as 8-bit bytes through a valid/ready handshake and are sent MSB first. Every bit takes a fixed window of whole reference periods. A zero is one burst at the start of the window followed by a quiet interval. A one is a burst at the start, a second burst later in the window, and a shorter quiet interval. The quiet half-duty periods between the two bursts of a one are part of that window. With the defaults, a 32 MHz system clock gives a 1 MHz reference: a burst lasts 31 periods, the second burst of a one starts at period 125, and a bit lasts 500 periods.

Top module: `cmdclk_tx`

## Requirements
- R1: `ref_clk` rises once every `REF_DIV` system cycles without exception, during idle, during transmission and from the first cycle after reset.
- R2: Each reference period has a high time of `REF_DIV/2` cycles (wide) or `REF_DIV/4` cycles (narrow, a marking period). The high time changes only at period boundaries.
- R3: A zero bit occupies `BIT_PERIODS` periods. Window periods 0 to `MARK_PERIODS-1` are narrow and all other periods are wide.
- R4: A one bit occupies `BIT_PERIODS` periods. Window periods 0 to `MARK_PERIODS-1` and `SECOND_AT` to `SECOND_AT+MARK_PERIODS-1` are narrow, and all other periods are wide.
- R5: The eight bit windows of a byte follow each other with no gap, each exactly `BIT_PERIODS` periods long.
- R6: Bits are sent MSB first (`cmd_data[7]` first, `cmd_data[0]` last).
- R7: `cmd_ready` is high when the block is idle. A byte is taken at a rising clock edge with `cmd_valid` and `cmd_ready` both high. `cmd_ready` is then low from the next cycle until the last period of the final bit window has ended. `cmd_valid` and `cmd_data` are ignored while `cmd_ready` is low.
- R8: While `rst_n` is low at a clock edge, the block drops any byte in progress and returns to idle. In the cycle after that edge, `ref_clk` is high at the start of a wide period and `cmd_ready` is high.
- R9: While no byte is pending or being sent, every period is wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, `REF_DIV` cycles per reference period |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_data | input | 8 | Command byte to send |
| cmd_valid | input | 1 | `cmd_data` holds a byte to send |
| cmd_ready | output | 1 | Block can take a byte |
| ref_clk | output | 1 | Reference clock carrying the duty-cycle code |

## Verification
The checker watches every cycle for a constant period (R1), for high times limited to the two legal widths (R2), for wide periods only while idle (R9), for the handshake dropping ready after a transfer (R7), and for the reset state (R8). The bit-level patterns (R3, R4), the back-to-back spacing of bit windows (R5), the bit order (R6), the point where ready returns, and the dropping of a byte cut off by reset can only be shown by the bench. It decodes the clock back into bits and compares them in order against the bytes it pushed to its scoreboard.

// File: rtl/cmdclk_tx.sv
module cmdclk_tx #(
  parameter int REF_DIV      = 32,
  parameter int BIT_PERIODS  = 500,
  parameter int MARK_PERIODS = 31,
  parameter int SECOND_AT    = 125
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cmd_data,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  output logic       ref_clk
);

  localparam int PW = $clog2(REF_DIV);
  localparam int BW = $clog2(BIT_PERIODS);
  localparam logic [PW:0] HI_WIDE   = (PW+1)'(REF_DIV / 2);
  localparam logic [PW:0] HI_NARROW = (PW+1)'(REF_DIV / 4);
  localparam logic [PW-1:0] PH_LAST = PW'(REF_DIV - 1);
  localparam logic [BW-1:0] PER_LAST = BW'(BIT_PERIODS - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SEND} state_t;

  state_t      state;
  logic [PW-1:0] ph;
  logic [BW-1:0] per;
  logic [2:0]  bitcnt;
  logic [7:0]  shreg;
  logic        narrow;
  logic        ref_q;

  function automatic logic is_mark(input logic [BW-1:0] p, input logic b);
    int pi;
    pi = int'(p);
    return (pi < MARK_PERIODS) ||
           (b && pi >= SECOND_AT && pi < SECOND_AT + MARK_PERIODS);
  endfunction

  wire        wrap  = (ph == PH_LAST);
  wire [PW:0] ph_n1 = {1'b0, ph} + 1'b1;
  wire [PW:0] hi    = narrow ? HI_NARROW : HI_WIDE;

  assign cmd_ready = (state == S_IDLE);
  assign ref_clk   = ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= '0;
      ref_q <= 1'b1;
    end else begin
      ph    <= wrap ? '0 : ph + 1'b1;
      ref_q <= wrap ? 1'b1 : (ph_n1 < hi);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      per    <= '0;
      bitcnt <= '0;
      shreg  <= '0;
      narrow <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (wrap) narrow <= 1'b0;
          if (cmd_valid) begin
            shreg <= cmd_data;
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (wrap) begin
            state  <= S_SEND;
            per    <= '0;
            bitcnt <= '0;
            narrow <= is_mark('0, shreg[7]);
          end
        end
        default: begin
          if (wrap) begin
            if (per == PER_LAST) begin
              per <= '0;
              if (bitcnt == 3'd7) begin
                state  <= S_IDLE;
                narrow <= 1'b0;
              end else begin
                bitcnt <= bitcnt + 1'b1;
                shreg  <= {shreg[6:0], 1'b0};
                narrow <= is_mark('0, shreg[6]);
              end
            end else begin
              per    <= per + 1'b1;
              narrow <= is_mark(per + 1'b1, shreg[7]);
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/cmdclk_tx_chk.sv
module cmdclk_tx_chk #(
  parameter int REF_DIV = 32
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic ref_clk
);

  localparam int CW = $clog2(REF_DIV) + 2;

  logic          prev_ref;
  logic          seen;
  logic          rdy_at_rise;
  logic [CW-1:0] per_cnt;
  logic [CW-1:0] hi_cnt;

  wire rise = ref_clk && !prev_ref;
  wire fall = !ref_clk && prev_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ref    <= 1'b1;
      seen        <= 1'b0;
      rdy_at_rise <= 1'b1;
      per_cnt     <= '0;
      hi_cnt      <= '0;
    end else begin
      prev_ref <= ref_clk;
      if (rise) begin
        seen        <= 1'b1;
        rdy_at_rise <= cmd_ready;
        per_cnt     <= CW'(1);
        hi_cnt      <= CW'(1);
      end else begin
        per_cnt <= per_cnt + 1'b1;
        if (ref_clk) hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  // R1
  period_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && seen) |-> per_cnt == CW'(REF_DIV));

  // R2
  high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && seen) |-> (hi_cnt == CW'(REF_DIV/2) || hi_cnt == CW'(REF_DIV/4)));

  // R9
  idle_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && seen && rdy_at_rise) |-> hi_cnt == CW'(REF_DIV/2));

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R8
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (ref_clk && cmd_ready));

endmodule

bind cmdclk_tx cmdclk_tx_chk #(.REF_DIV(REF_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .ref_clk(ref_clk)
);

// File: tb/cmdclk_tx_tb.sv
module cmdclk_tx_tb;
  localparam int DIV    = 8;
  localparam int BITP   = 16;
  localparam int MARK   = 2;
  localparam int SECOND = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cmd_data = '0;
  logic cmd_valid = 1'b0;
  logic cmd_ready, ref_clk;

  int checks = 0, failures = 0, cyc = 0;
  logic [2:0] exq[$];

  always #2 clk = ~clk;

  cmdclk_tx #(.REF_DIV(DIV), .BIT_PERIODS(BITP), .MARK_PERIODS(MARK),
              .SECOND_AT(SECOND)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .ref_clk(ref_clk));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: decodes ref_clk into bit windows and compares with the scoreboard
  logic prev_ref = 1'b1, prev_rdy = 1'b1, started = 1'b0, inbit = 1'b0;
  int last_rise = 0, hcnt = 0, pidx = 0, bstart = 0, pos = 0, prev_end = 0;
  logic [BITP-1:0] pat = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      prev_ref = 1'b1; started = 1'b0; inbit = 1'b0; hcnt = 0;
      exq.delete();
    end else begin
      if (ref_clk && !prev_ref) begin
        if (started) begin
          logic narrow;
          chk(cyc - last_rise == DIV, "R1", "period length", cyc - last_rise, DIV);
          chk(hcnt == DIV/2 || hcnt == DIV/4, "R2", "high time", hcnt, DIV/2);
          narrow = (hcnt == DIV/4);
          pidx++;
          if (!inbit && narrow) begin
            inbit = 1'b1; pos = 0; pat = '0; bstart = pidx;
          end
          if (inbit) begin
            pat[pos] = narrow;
            pos++;
            if (pos == BITP) begin
              inbit = 1'b0;
              if (exq.size() == 0) begin
                chk(0, "R9", "unexpected bit window", pat, 0);
              end else begin
                logic [2:0] it;
                logic [BITP-1:0] ep;
                it = exq.pop_front();
                ep = '0;
                for (int k = 0; k < BITP; k++)
                  ep[k] = (k < MARK) || (it[0] && k >= SECOND && k < SECOND + MARK);
                chk(pat == ep, it[0] ? "R4" : "R3", "bit pattern (R6 order)", pat, ep);
                if (!it[2])
                  chk(bstart == prev_end, "R5", "window spacing", bstart, prev_end);
                if (it[1]) begin
                  chk(cmd_ready && !prev_rdy, "R7", "ready returns after last window",
                      {prev_rdy, cmd_ready}, 2'b01);
                end
                prev_end = bstart + BITP;
              end
            end
          end
        end
        started = 1'b1; last_rise = cyc; hcnt = 1;
      end else if (ref_clk) begin
        hcnt++;
      end
      prev_ref = ref_clk;
    end
    prev_rdy = cmd_ready;
  end

  task automatic send_byte(input logic [7:0] d);
    while (!cmd_ready) @(negedge clk);
    cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    for (int i = 7; i >= 0; i--) exq.push_back({i == 7, i == 0, d[i]});
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R7", "ready low after accept", cmd_ready, 0);
  endtask

  task automatic wait_idle();
    while (!cmd_ready || exq.size() != 0) @(negedge clk);
    repeat (3 * DIV) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ref_clk == 1'b1, "R8", "ref_clk in reset", ref_clk, 1);
    chk(cmd_ready == 1'b1, "R8", "ready in reset", cmd_ready, 1);
    rst_n = 1'b1;
    repeat (6 * DIV) @(negedge clk);
    chk(exq.size() == 0 && !inbit, "R9", "idle has no bursts", inbit, 0);

    send_byte(8'hA5);
    cmd_data = 8'h00; cmd_valid = 1'b1;
    repeat (300) begin
      @(negedge clk);
      if (cmd_ready) chk(0, "R7", "ready high while sending", cmd_ready, 0);
    end
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R7", "ready still low mid byte", cmd_ready, 0);
    wait_idle();

    send_byte(8'hFF);
    send_byte(8'h00);
    send_byte(8'h81);
    wait_idle();

    send_byte(8'h3C);
    repeat (5 * BITP * DIV / 2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ref_clk == 1'b1, "R8", "ref_clk after mid-byte reset", ref_clk, 1);
    chk(cmd_ready == 1'b1, "R8", "ready after mid-byte reset", cmd_ready, 1);
    rst_n = 1'b1;
    repeat (3 * BITP * DIV) @(negedge clk);
    chk(!inbit, "R8", "no bursts after reset", inbit, 0);

    send_byte(8'h5A);
    wait_idle();
    chk(exq.size() == 0, "R6", "scoreboard drained", exq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule